// File: doc/BRIEF.md
# Working-Zone Address Bus Encoder and Decoder

This block lowers switching activity on a wide address bus. Programs tend to spend most of their run time inside a few small address windows. The encoder tracks four such windows, called working zones. Each zone is identified by a base address and spans as many consecutive addresses as the bus has wires. When an address falls inside a tracked zone, the encoder does not send the address. It sends a single set wire whose position is the offset from that zone's base. A hit flag and a two-bit zone index travel on side lines next to the bus. Two consecutive transfers inside the same zone therefore change at most two bus wires.

An address that misses every zone is sent in full with the hit flag low. That address then becomes the base of the least recently used zone. The receiving decoder holds a mirrored copy of the zone bases and of the recency order. It applies the same replacement on every miss, so the two ends stay in step without any extra traffic. The top module joins both ends. It exposes the encoded bus for observation and returns the rebuilt address one cycle after the address is presented.

Top module: `wz_codec`

## Requirements
- R1: After reset no zone is valid: `bus_valid` and `out_valid` are low, and the first transfer after reset is sent with `bus_hit` low and the raw address on `bus_lines`.
- R2: Each cycle with `in_valid` high is followed one cycle later by `out_valid` high, with `out_addr` equal to the address that was presented.
- R3: An address A hits zone z when z holds a valid base B and (A - B) modulo 2^AW is below AW. The encoded word then has `bus_hit`=1, `bus_zone`=z, and `bus_lines` with only bit (A - B) set.
- R4: An address that hits no zone appears on `bus_lines` unchanged, with `bus_hit`=0.
- R5: On a miss, the zone that was least recently filled or hit takes the missed address as its new base, and `bus_zone` carries that zone's index. Directly after reset, zones are filled in the order 0, 1, 2, 3.
- R6: When an address lies inside more than one zone, the lowest-numbered zone is used and counts as touched.
- R7: A cycle with `in_valid` low gives `bus_valid` low in the next cycle. `bus_lines`, `bus_hit` and `bus_zone` keep their values, and no zone base or recency order changes.
- R8: Zone ranges wrap modulo 2^AW. A base near the top of the address space covers the lowest addresses that follow it.
- R9: Two back-to-back hit transfers differ in at most two bus wires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Address to be sent this cycle |
| in_addr | input | AW (16) | Address presented to the encoder |
| bus_valid | output | 1 | Encoded bus carries a transfer |
| bus_lines | output | AW (16) | Encoded bus: one-hot offset on a hit, raw address on a miss |
| bus_hit | output | 1 | Side line: the transfer is a zone hit |
| bus_zone | output | 2 | Side line: zone used by a hit, or zone replaced by a miss |
| out_valid | output | 1 | Rebuilt address is valid |
| out_addr | output | AW (16) | Address rebuilt by the decoder |

## Verification
The hardest cases to reach from the ports are overlapping zones and eviction ordering once all four zones are full. An overlap only exists if a lower base is loaded after a higher one that lies within one zone width of it. Eviction ordering depends on the full history of hits. The stimulus builds both cases on purpose: it fills the zones in a chosen order, reorders their recency with selected hits, and loads bases 8 apart in descending order to create overlaps. A long pseudo-random phase then mixes clustered addresses, wrap-around bases and idle cycles against a recency model kept in the bench.

// File: rtl/wz_pkg.sv
package wz_pkg;
  localparam int unsigned WZ_ADDR_W = 16;
  localparam int unsigned WZ_ZONES  = 4;
endpackage

// File: rtl/wz_rst_sync.sv
module wz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wz_lru.sv
module wz_lru #(
  parameter int unsigned ZONES = 4,
  parameter int unsigned ZW    = $clog2(ZONES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [ZW-1:0] touch_idx,
  output logic [ZW-1:0] victim
);
  localparam logic [ZW-1:0] OLDEST = ZW'(ZONES - 1);

  logic [ZW-1:0] age_q [ZONES];
  logic [ZW-1:0] age_d [ZONES];

  always_comb begin
    victim = '0;
    for (int j = 0; j < ZONES; j++) begin
      if (age_q[j] == OLDEST) victim = ZW'(j);
    end
  end

  always_comb begin
    for (int j = 0; j < ZONES; j++) begin
      age_d[j] = age_q[j];
      if (touch_en) begin
        if (ZW'(j) == touch_idx)
          age_d[j] = '0;
        else if (age_q[j] < age_q[touch_idx])
          age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ZONES; j++) age_q[j] <= ZW'(ZONES - 1 - j);
    end else if (touch_en) begin
      for (int j = 0; j < ZONES; j++) age_q[j] <= age_d[j];
    end
  end
endmodule

// File: rtl/wz_zone_match.sv
module wz_zone_match #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = $clog2(AW)
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic          zone_ok,
  output logic          hit,
  output logic [PW-1:0] offset
);
  logic [AW-1:0] diff;

  always_comb begin
    diff   = addr - base;
    hit    = zone_ok && (diff < AW'(AW));
    offset = diff[PW-1:0];
  end
endmodule

// File: rtl/wz_encoder.sv
module wz_encoder #(
  parameter int unsigned AW    = 16,
  parameter int unsigned ZONES = 4,
  parameter int unsigned ZW    = $clog2(ZONES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic          bus_valid,
  output logic [AW-1:0] bus_lines,
  output logic          bus_hit,
  output logic [ZW-1:0] bus_zone
);
  localparam int unsigned PW = $clog2(AW);

  logic [AW-1:0] base_q [ZONES];
  logic [ZONES-1:0] zval_q;
  logic [ZONES-1:0] hit_vec;
  logic [PW-1:0]    off_arr [ZONES];
  logic             any_hit;
  logic [ZW-1:0]    hit_idx;
  logic [PW-1:0]    hit_off;
  logic [ZW-1:0]    victim;
  logic [ZW-1:0]    touch_idx;
  logic [AW-1:0]    lines_d;

  for (genvar z = 0; z < ZONES; z++) begin : g_match
    wz_zone_match #(.AW(AW), .PW(PW)) u_match (
      .addr    (in_addr),
      .base    (base_q[z]),
      .zone_ok (zval_q[z]),
      .hit     (hit_vec[z]),
      .offset  (off_arr[z])
    );
  end

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    hit_off = '0;
    for (int z = ZONES - 1; z >= 0; z--) begin
      if (hit_vec[z]) begin
        any_hit = 1'b1;
        hit_idx = ZW'(z);
        hit_off = off_arr[z];
      end
    end
    touch_idx = any_hit ? hit_idx : victim;
    lines_d   = any_hit ? (AW'(1) << hit_off) : in_addr;
  end

  wz_lru #(.ZONES(ZONES), .ZW(ZW)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (in_valid),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int z = 0; z < ZONES; z++) base_q[z] <= '0;
      zval_q <= '0;
    end else if (in_valid && !any_hit) begin
      base_q[victim] <= in_addr;
      zval_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_lines <= '0;
      bus_hit   <= 1'b0;
      bus_zone  <= '0;
    end else begin
      bus_valid <= in_valid;
      if (in_valid) begin
        bus_lines <= lines_d;
        bus_hit   <= any_hit;
        bus_zone  <= touch_idx;
      end
    end
  end
endmodule

// File: rtl/wz_decoder.sv
module wz_decoder #(
  parameter int unsigned AW    = 16,
  parameter int unsigned ZONES = 4,
  parameter int unsigned ZW    = $clog2(ZONES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_lines,
  input  logic          bus_hit,
  input  logic [ZW-1:0] bus_zone,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);
  localparam int unsigned PW = $clog2(AW);

  logic [AW-1:0] base_q [ZONES];
  logic [ZW-1:0] victim;
  logic [ZW-1:0] touch_idx;
  logic [PW-1:0] pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < AW; i++) begin
      if (bus_lines[i]) pos = PW'(i);
    end
    touch_idx = bus_hit ? bus_zone : victim;
    out_valid = bus_valid;
    out_addr  = bus_hit ? (base_q[bus_zone] + AW'(pos)) : bus_lines;
  end

  wz_lru #(.ZONES(ZONES), .ZW(ZW)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (bus_valid),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int z = 0; z < ZONES; z++) base_q[z] <= '0;
    end else if (bus_valid && !bus_hit) begin
      base_q[victim] <= bus_lines;
    end
  end
endmodule

// File: rtl/wz_codec.sv
module wz_codec
  import wz_pkg::*;
#(
  parameter int unsigned AW    = WZ_ADDR_W,
  parameter int unsigned ZONES = WZ_ZONES,
  parameter int unsigned ZW    = $clog2(ZONES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic          bus_valid,
  output logic [AW-1:0] bus_lines,
  output logic          bus_hit,
  output logic [ZW-1:0] bus_zone,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);
  logic rst_sync_n;

  wz_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wz_encoder #(.AW(AW), .ZONES(ZONES), .ZW(ZW)) u_enc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .bus_valid (bus_valid),
    .bus_lines (bus_lines),
    .bus_hit   (bus_hit),
    .bus_zone  (bus_zone)
  );

  wz_decoder #(.AW(AW), .ZONES(ZONES), .ZW(ZW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_lines (bus_lines),
    .bus_hit   (bus_hit),
    .bus_zone  (bus_zone),
    .out_valid (out_valid),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/wz_codec_chk.sv
module wz_codec_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned ZW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] in_addr,
  input logic          bus_valid,
  input logic [AW-1:0] bus_lines,
  input logic          bus_hit,
  input logic [ZW-1:0] bus_zone,
  input logic          out_valid,
  input logic [AW-1:0] out_addr
);
  logic armed;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      seen  <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (bus_valid) seen <= 1'b1;
    end
  end

  // R1
  first_is_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && bus_valid) |-> !bus_hit);

  // R2
  round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid) |=> (out_valid && out_addr == $past(in_addr)));

  // R3
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_hit) |-> ($countones(bus_lines) == 1));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !in_valid) |=> (!bus_valid && $stable(bus_lines) && $stable(bus_hit) && $stable(bus_zone)));

  // R9
  two_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_valid && bus_hit && $past(bus_valid && bus_hit))
      |-> ($countones(bus_lines ^ $past(bus_lines)) <= 2));
endmodule

bind wz_codec wz_codec_chk #(.AW(AW), .ZW(ZW)) u_chk (.*);

// File: tb/wz_codec_test.sv
`timescale 1ns/1ps
module wz_codec_test;
  localparam int AW = 16;
  localparam int NZ = 4;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] in_addr;
  logic          bus_valid;
  logic [AW-1:0] bus_lines;
  logic          bus_hit;
  logic [1:0]    bus_zone;
  logic          out_valid;
  logic [AW-1:0] out_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [AW-1:0] m_base [NZ];
  bit            m_val  [NZ];
  int            m_age  [NZ];
  bit            first_xfer;
  bit            prev_hit;
  logic [AW-1:0] prev_lines;

  wz_codec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .bus_valid(bus_valid), .bus_lines(bus_lines), .bus_hit(bus_hit),
    .bus_zone(bus_zone), .out_valid(out_valid), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int z = 0; z < NZ; z++) begin
      m_base[z] = '0;
      m_val[z]  = 0;
      m_age[z]  = NZ - 1 - z;
    end
    first_xfer = 1;
    prev_hit   = 0;
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_addr  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
    check(bus_valid == 1'b0, "R1 bus_valid after reset", bus_valid, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic xfer(input logic [AW-1:0] a);
    int hz, nhit, off, vic, touch, ta;
    logic [AW-1:0] d;
    logic [AW-1:0] exp_lines;
    bit wrapped;
    string t_hit, t_line;
    hz = -1; nhit = 0; off = 0; vic = 0; wrapped = 0;
    for (int z = 0; z < NZ; z++) begin
      d = a - m_base[z];
      if (m_val[z] && d < AW) begin
        nhit++;
        if (hz < 0) begin
          hz = z;
          off = int'(d);
          wrapped = (int'(m_base[z]) + off) > 16'hFFFF;
        end
      end
    end
    for (int z = 0; z < NZ; z++) if (m_age[z] == NZ - 1) vic = z;
    touch = (hz >= 0) ? hz : vic;
    if (hz < 0) begin
      m_base[vic] = a;
      m_val[vic]  = 1;
    end
    ta = m_age[touch];
    for (int j = 0; j < NZ; j++) begin
      if (j == touch) m_age[j] = 0;
      else if (m_age[j] < ta) m_age[j] = m_age[j] + 1;
    end
    exp_lines = (hz >= 0) ? (AW'(1) << off) : a;
    if (first_xfer) begin t_hit = "R1"; t_line = "R1"; end
    else if (hz < 0) begin t_hit = "R4"; t_line = "R4"; end
    else if (wrapped) begin t_hit = "R8"; t_line = "R8"; end
    else begin t_hit = "R3"; t_line = "R3"; end

    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    check(bus_valid == 1'b1, {t_hit, " bus_valid"}, bus_valid, 1);
    check(bus_hit == (hz >= 0), {t_hit, " bus_hit"}, bus_hit, (hz >= 0));
    check(bus_lines == exp_lines, {t_line, " bus_lines"}, bus_lines, exp_lines);
    if (hz < 0)
      check(bus_zone == 2'(vic), "R5 replaced zone", bus_zone, vic);
    else if (nhit > 1)
      check(bus_zone == 2'(hz), "R6 lowest overlapping zone", bus_zone, hz);
    else
      check(bus_zone == 2'(hz), {t_hit, " bus_zone"}, bus_zone, hz);
    check(out_valid && out_addr == a, "R2 rebuilt address", out_addr, a);
    if (prev_hit && hz >= 0)
      check($countones(prev_lines ^ bus_lines) <= 2, "R9 wires changed",
            $countones(prev_lines ^ bus_lines), 2);
    prev_hit   = (hz >= 0);
    prev_lines = bus_lines;
    first_xfer = 0;
  endtask

  task automatic idle();
    logic [AW-1:0] l;
    logic h;
    logic [1:0] zz;
    l = bus_lines; h = bus_hit; zz = bus_zone;
    in_valid = 1'b0;
    @(negedge clk);
    check(bus_valid == 1'b0, "R7 bus_valid idle", bus_valid, 0);
    check(out_valid == 1'b0, "R7 out_valid idle", out_valid, 0);
    check(bus_lines == l && bus_hit == h && bus_zone == zz, "R7 bus held", bus_lines, l);
    prev_hit = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [15:0] regions [4];
    do_reset();
    // R1 first address after reset, then fill order R5
    xfer(16'h1000);
    xfer(16'h2000);
    xfer(16'h3000);
    xfer(16'h4000);
    // R3 R9 exhaustive offsets in every zone
    for (int z = 0; z < NZ; z++)
      for (int o = 0; o < AW; o++) xfer(16'(16'h1000 * (z + 1) + o));
    // R4 just past a zone; R5 LRU victim is zone 0
    xfer(16'h1010);
    // reorder recency then miss twice, R5
    xfer(16'h2001);
    xfer(16'h1015);
    xfer(16'h3002);
    xfer(16'h8000);
    xfer(16'h9000);
    // R7 idle cycles hold bus and state
    idle();
    idle();
    xfer(16'h8003);
    xfer(16'h9004);
    // R6 overlapping zones: higher base loaded first
    do_reset();
    xfer(16'h5008);
    xfer(16'h5000);
    for (int o = 0; o < 24; o++) xfer(16'(16'h5000 + o));
    // R8 wrap-around zone
    xfer(16'hFFF8);
    for (int o = 0; o < AW; o++) xfer(16'(16'hFFF8 + o));
    xfer(16'h0008);
    // R2 long mixed sweep
    regions[0] = 16'h0100; regions[1] = 16'h7FF0;
    regions[2] = 16'hFFF4; regions[3] = 16'h2468;
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) idle();
      else xfer(16'(regions[lfsr[4:3]] + {lfsr[11:8], lfsr[5]} ));
    end
    in_valid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule